// File: doc/BRIEF.md
# Programmable-Timing Burst Read Controller

This block runs read cycles on an external static memory, ROM or peripheral bank. The timing comes from a bank configuration that is captured when a request is accepted. The configuration sets the chip-select delay, the output-enable delay, the first-beat wait count, the wait count for later beats, the hold length, burst enable and bus width. An internal agent starts a read by presenting a byte address and a word count. It then receives one data word per beat, a done pulse, and an error flag together with the index of the failing beat.

The controller steps through four states:

- `ST_IDLE`: the bus is released.
- `ST_FIRST`: the first beat of an access, including the chip-select and output-enable delays.
- `ST_NEXT`: each later beat of a burst.
- `ST_HOLD`: the tail after the final beat, during which every bus output is frozen.

The transitions are named as follows:

- **accept** (IDLE→FIRST)
- **first-to-burst** (FIRST→NEXT)
- **beat-to-beat** (NEXT→NEXT)
- **final-beat** (FIRST/NEXT→HOLD). It also covers a beat that ends with a bus error.
- **re-access** (HOLD→FIRST). This is used when burst mode is off and words remain.
- **release** (HOLD→IDLE)

Top module: `burst_rd_ctrl`

## Requirements
- R1: A request is accepted only in ST_IDLE when `req_start` is high. The configuration inputs, address and length are captured then. While busy, `req_start` is ignored. A length of 0 is treated as 1.
- R2: In the first beat of each access, `bus_cs` is high from cycle `cfg_cs_dly` onward, counting from the first cycle the address is driven as cycle 0. It then stays high until the bus is released.
- R3: In the first beat, `bus_oe` is high from cycle `cfg_cs_dly+cfg_oe_dly` onward. It is never high without `bus_cs`.
- R4: The first beat lasts E+1 cycles, where E = max(`cfg_wait`, `cfg_cs_dly+cfg_oe_dly`). No output changes during wait cycles beyond the strobe delays.
- R5: Each later burst beat lasts `cfg_bwait`+1 cycles. At the start of each beat the byte address advances by 1, 2 or 4, for `cfg_width` codes 00 (byte), 01 (halfword) and 1x (word). `bus_addr` carries byte-address bits [AW-1:2].
- R6: `bus_rdata` is captured on the last cycle of every beat. `rsp_valid` is high for exactly the next cycle, and `rsp_data` holds the captured word.
- R7: `bus_last` is high during the final beat of a burst, during every beat when burst mode is off, and throughout the hold that follows. Otherwise it is low.
- R8: The hold phase lasts max(`cfg_hold`,1) cycles with all bus outputs frozen. In the next cycle `bus_cs`, `bus_oe`, `bus_last` and `req_busy` are low and `rsp_done` pulses for one cycle.
- R9: `bus_be` is 1111 for word width. For byte or halfword width it is {1,1,addr[1],addr[0]}, which carries the two low byte-address bits.
- R10: When `bus_err` is high on the last cycle of a beat, all remaining beats are skipped and the address does not step. The hold still runs. At done, `rsp_err` is 1 and `rsp_err_beat` holds the 0-based word index. Both stay until the next accepted request.
- R11: With burst mode off, each word is a separate access with its own full first-beat timing and hold. The address steps between accesses, and `rsp_done` follows only the last access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_burst_en | input | 1 | Burst mode enable |
| cfg_width | input | 2 | Bus width: 00 byte, 01 halfword, 1x word |
| cfg_wait | input | 4 | First-beat wait count |
| cfg_bwait | input | 2 | Later-beat wait count |
| cfg_cs_dly | input | 1 | Chip-select delay of one cycle |
| cfg_oe_dly | input | 1 | Output-enable delay of one cycle after chip select |
| cfg_hold | input | 3 | Hold length in cycles |
| req_start | input | 1 | Start a read request |
| req_addr | input | AW | Start byte address |
| req_len | input | LW | Number of words |
| req_busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | Read word valid |
| rsp_data | output | DW | Read word |
| rsp_done | output | 1 | Request complete pulse |
| rsp_err | output | 1 | Request ended on a bus error |
| rsp_err_beat | output | LW | Index of the failing word |
| bus_addr | output | AW-2 | Bus word address |
| bus_be | output | 4 | Byte enables, or low address bits for narrow widths |
| bus_cs | output | 1 | Chip select, active high |
| bus_oe | output | 1 | Output enable, active high |
| bus_last | output | 1 | Final-beat indication |
| bus_rdata | input | DW | Read data from the bank |
| bus_err | input | 1 | Bus error, sampled at beat end |

## Verification
Capturing data at the end of a beat and deciding whether to advance to another beat happen on the same clock edge. A bus error arriving on that edge has to win over both the address step and the state change. The bench provokes this by placing an error on a middle beat of a word burst, and on the second access of a split request.

The result is judged at the pins:

- the error beat's word is still delivered;
- the address stays at the failing word through the hold;
- no further beats appear;
- `rsp_done` arrives with `rsp_err` set and the right beat index.

// File: rtl/brc_pkg.sv
package brc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_NEXT  = 2'd2,
        ST_HOLD  = 2'd3
    } brc_state_e;

    typedef struct packed {
        logic       burst;
        logic [1:0] width;
        logic [3:0] wait_n;
        logic [1:0] bwait;
        logic       cs_dly;
        logic       oe_dly;
        logic [2:0] hold;
    } brc_cfg_t;
endpackage

// File: rtl/brc_phase_dec.sv
module brc_phase_dec
    import brc_pkg::*;
(
    input  brc_state_e st,
    input  logic [3:0] cnt,
    input  logic       cs_dly,
    input  logic       oe_dly,
    input  logic [3:0] wait_n,
    input  logic [2:0] hold,
    output logic [3:0] first_end,
    output logic [2:0] hold_end,
    output logic       cs_on,
    output logic       oe_on
);
    logic [3:0] strobe_sum;

    always_comb begin
        strobe_sum = {3'b000, cs_dly} + {3'b000, oe_dly};
        // a wait shorter than the strobe delays is stretched to them
        first_end  = (wait_n < strobe_sum) ? strobe_sum : wait_n;
        hold_end   = (hold == 3'd0) ? 3'd0 : hold - 3'd1;
        if (st == ST_FIRST) begin
            cs_on = (cnt >= {3'b000, cs_dly});
            oe_on = (cnt >= strobe_sum);
        end else begin
            cs_on = (st != ST_IDLE);
            oe_on = (st != ST_IDLE);
        end
    end
endmodule

// File: rtl/brc_addr_gen.sv
module brc_addr_gen #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    input  logic [1:0]    width,
    output logic [AW-1:2] word_addr,
    output logic [3:0]    be
);
    logic [AW-1:0] addr_q;
    logic [2:0]    step_sz;

    always_comb begin
        unique case (width)
            2'b00:   step_sz = 3'd1;
            2'b01:   step_sz = 3'd2;
            default: step_sz = 3'd4;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= load_addr;
        else if (step) addr_q <= addr_q + AW'(step_sz);
    end

    assign word_addr = addr_q[AW-1:2];
    assign be        = width[1] ? 4'b1111 : {2'b11, addr_q[1], addr_q[0]};
endmodule

// File: rtl/burst_rd_ctrl.sv
module burst_rd_ctrl
    import brc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_burst_en,
    input  logic [1:0]    cfg_width,
    input  logic [3:0]    cfg_wait,
    input  logic [1:0]    cfg_bwait,
    input  logic          cfg_cs_dly,
    input  logic          cfg_oe_dly,
    input  logic [2:0]    cfg_hold,
    input  logic          req_start,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    output logic          req_busy,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_done,
    output logic          rsp_err,
    output logic [LW-1:0] rsp_err_beat,
    output logic [AW-3:0] bus_addr,
    output logic [3:0]    bus_be,
    output logic          bus_cs,
    output logic          bus_oe,
    output logic          bus_last,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_err
);
    brc_state_e    st_q, st_d;
    brc_cfg_t      cfg_q, cfg_in;
    logic [3:0]    cnt_q;
    logic [LW-1:0] left_q, idx_q, err_beat_q;
    logic          last_q, err_q;
    logic [3:0]    first_end;
    logic [2:0]    hold_end;
    logic          cs_on, oe_on;
    logic          start_ok, beat_end, hold_done, more, beat_last, step_addr;

    assign cfg_in = '{burst: cfg_burst_en, width: cfg_width, wait_n: cfg_wait,
                      bwait: cfg_bwait, cs_dly: cfg_cs_dly, oe_dly: cfg_oe_dly,
                      hold: cfg_hold};

    brc_phase_dec u_phase (
        .st(st_q), .cnt(cnt_q), .cs_dly(cfg_q.cs_dly), .oe_dly(cfg_q.oe_dly),
        .wait_n(cfg_q.wait_n), .hold(cfg_q.hold), .first_end(first_end),
        .hold_end(hold_end), .cs_on(cs_on), .oe_on(oe_on)
    );

    always_comb begin
        start_ok  = (st_q == ST_IDLE) && req_start;
        beat_end  = ((st_q == ST_FIRST) && (cnt_q == first_end)) ||
                    ((st_q == ST_NEXT) && (cnt_q == {2'b00, cfg_q.bwait}));
        hold_done = (st_q == ST_HOLD) && (cnt_q == {1'b0, hold_end});
        more      = (left_q != '0);
        beat_last = !more || !cfg_q.burst;
        step_addr = (beat_end && !bus_err && more && cfg_q.burst) ||
                    (hold_done && more && !err_q && !cfg_q.burst);
    end

    brc_addr_gen #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(start_ok), .load_addr(req_addr),
        .step(step_addr), .width(cfg_q.width), .word_addr(bus_addr), .be(bus_be)
    );

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (req_start) st_d = ST_FIRST;
            ST_FIRST,
            ST_NEXT:  if (beat_end) st_d = (bus_err || beat_last) ? ST_HOLD : ST_NEXT;
            ST_HOLD:  if (hold_done)
                          st_d = (more && !err_q && !cfg_q.burst) ? ST_FIRST : ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register, counters and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            cfg_q      <= '0;
            cnt_q      <= '0;
            left_q     <= '0;
            idx_q      <= '0;
            last_q     <= 1'b0;
            err_q      <= 1'b0;
            err_beat_q <= '0;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
            rsp_done   <= 1'b0;
        end else begin
            st_q      <= st_d;
            rsp_valid <= 1'b0;
            rsp_done  <= 1'b0;
            if (start_ok || beat_end || hold_done) cnt_q <= '0;
            else if (st_q != ST_IDLE)              cnt_q <= cnt_q + 4'd1;
            if (start_ok) begin
                cfg_q      <= cfg_in;
                left_q     <= (req_len == '0) ? '0 : req_len - LW'(1);
                idx_q      <= '0;
                err_q      <= 1'b0;
                err_beat_q <= '0;
            end
            if (beat_end) begin
                rsp_valid <= 1'b1;
                rsp_data  <= bus_rdata;
                last_q    <= beat_last;
                if (bus_err) begin
                    err_q      <= 1'b1;
                    err_beat_q <= idx_q;
                end else if (more && cfg_q.burst) begin
                    left_q <= left_q - LW'(1);
                    idx_q  <= idx_q + LW'(1);
                end
            end
            if (hold_done) begin
                if (more && !err_q && !cfg_q.burst) begin
                    left_q <= left_q - LW'(1);
                    idx_q  <= idx_q + LW'(1);
                end else begin
                    rsp_done <= 1'b1;
                end
            end
        end
    end

    // bus and request outputs
    always_comb begin
        bus_cs       = cs_on;
        bus_oe       = oe_on;
        req_busy     = (st_q != ST_IDLE);
        rsp_err      = err_q;
        rsp_err_beat = err_beat_q;
        unique case (st_q)
            ST_FIRST, ST_NEXT: bus_last = beat_last;
            ST_HOLD:           bus_last = last_q;
            default:           bus_last = 1'b0;
        endcase
    end
endmodule

// File: rtl/brc_checker.sv
module brc_checker (
    input logic clk,
    input logic rst_n,
    input logic req_busy,
    input logic bus_cs,
    input logic bus_oe,
    input logic bus_last,
    input logic rsp_valid,
    input logic rsp_done
);
    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> bus_cs); // R3
    AST_VALID_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(bus_oe)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_busy |-> (!bus_cs && !bus_oe && !bus_last)); // R8
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (!req_busy && $past(bus_cs))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R8
endmodule

bind burst_rd_ctrl brc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_busy(req_busy), .bus_cs(bus_cs),
    .bus_oe(bus_oe), .bus_last(bus_last), .rsp_valid(rsp_valid), .rsp_done(rsp_done)
);

// File: tb/burst_rd_ctrl_tb.sv
module burst_rd_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_burst_en = 1'b0;
    logic [1:0]  cfg_width = 2'b10;
    logic [3:0]  cfg_wait = '0;
    logic [1:0]  cfg_bwait = '0;
    logic        cfg_cs_dly = 1'b0;
    logic        cfg_oe_dly = 1'b0;
    logic [2:0]  cfg_hold = '0;
    logic        req_start = 1'b0;
    logic [31:0] req_addr = '0;
    logic [4:0]  req_len = '0;
    logic        req_busy, rsp_valid, rsp_done, rsp_err;
    logic [31:0] rsp_data, bus_rdata;
    logic [4:0]  rsp_err_beat;
    logic [29:0] bus_addr;
    logic [3:0]  bus_be;
    logic        bus_cs, bus_oe, bus_last, bus_err;
    logic        err_en = 1'b0;
    logic [29:0] err_word = '0;

    int nchk = 0, nfail = 0, poke_cnt = 0;
    bit pend = 0, finished = 0;
    logic [31:0] pend_data;

    always #5 clk = ~clk;

    assign bus_rdata = {bus_addr, 2'b00} ^ 32'h5A5A_0F0F;
    assign bus_err   = err_en && (bus_addr == err_word);

    burst_rd_ctrl u_dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // one sampled cycle of an access; every bus output compared
    task automatic cyc(input string sc, input bit ecs, input bit eoe, input bit elast,
                       input logic [31:0] a, input logic [1:0] w);
        logic [3:0] ebe;
        @(negedge clk);
        if (poke_cnt > 0) begin
            poke_cnt--; req_start = 1'b1; req_addr = 32'h0000_F000;
        end else req_start = 1'b0;
        ebe = w[1] ? 4'hF : {2'b11, a[1:0]};
        chk(rsp_valid == pend, {sc, " R6 valid"}, 32'(rsp_valid), 32'(pend));
        if (pend) chk(rsp_data == pend_data, {sc, " R6 data"}, rsp_data, pend_data);
        pend = 0;
        chk(bus_cs == ecs, {sc, " R2 cs"}, 32'(bus_cs), 32'(ecs));
        chk(bus_oe == eoe, {sc, " R3 oe"}, 32'(bus_oe), 32'(eoe));
        chk(bus_last == elast, {sc, " R7 last"}, 32'(bus_last), 32'(elast));
        chk(bus_addr == a[31:2], {sc, " R5 addr"}, 32'(bus_addr), 32'(a[31:2]));
        chk(bus_be == ebe, {sc, " R9 be"}, 32'(bus_be), 32'(ebe));
    endtask

    task automatic run(input string sc, input bit bu, input logic [1:0] w, input logic [3:0] wt,
                       input logic [1:0] bw, input bit csd, input bit oed, input logic [2:0] hd,
                       input logic [31:0] addr, input logic [4:0] len, input int err_at, input bit poke);
        int weff, n, step, beat, h;
        bit stop, hit, lastv;
        logic [31:0] a;
        @(negedge clk);
        cfg_burst_en = bu; cfg_width = w; cfg_wait = wt; cfg_bwait = bw;
        cfg_cs_dly = csd; cfg_oe_dly = oed; cfg_hold = hd;
        req_addr = addr; req_len = len; req_start = 1'b1;
        err_en = (err_at >= 0);
        err_word = addr[31:2] + 30'(err_at);
        weff = (int'(wt) < int'(csd) + int'(oed)) ? int'(csd) + int'(oed) : int'(wt);   // R4
        n = (len == 0) ? 1 : int'(len);                                                // R1
        step = (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
        a = addr; beat = 0; stop = 0; hit = 0; pend = 0;
        poke_cnt = poke ? weff : 0;
        while (!stop) begin
            lastv = bu ? (beat == n - 1) : 1'b1;
            for (int c = 0; c <= weff; c++)
                cyc({sc, " R4"}, c >= int'(csd), c >= int'(csd) + int'(oed), lastv, a, w);
            pend = 1; pend_data = {a[31:2], 2'b00} ^ 32'h5A5A_0F0F;
            hit = (beat == err_at);
            while (bu && !hit && beat < n - 1) begin
                beat++; a += 32'(step);
                lastv = (beat == n - 1);
                for (int c = 0; c <= int'(bw); c++) cyc({sc, " R5 beat"}, 1, 1, lastv, a, w);
                pend = 1; pend_data = {a[31:2], 2'b00} ^ 32'h5A5A_0F0F;
                hit = (beat == err_at);
            end
            h = (hd == 0) ? 1 : int'(hd);
            for (int c = 0; c < h; c++) cyc({sc, " R8 hold"}, 1, 1, lastv, a, w);
            if (!hit && !bu && beat < n - 1) begin
                beat++; a += 32'(step);   // R11 next separate access
            end else stop = 1;
        end
        @(negedge clk);
        chk(!req_busy && !bus_cs && !bus_oe && !bus_last, {sc, " R8 released"},
            {req_busy, bus_cs, bus_oe, bus_last}, 0);
        chk(rsp_done == 1'b1, {sc, " R8 done"}, 32'(rsp_done), 1);
        chk(rsp_err == (err_at >= 0), {sc, " R10 err"}, 32'(rsp_err), 32'(err_at >= 0));
        if (err_at >= 0) chk(rsp_err_beat == 5'(err_at), {sc, " R10 beat"}, 32'(rsp_err_beat), err_at);
        @(negedge clk);
        chk(rsp_done == 1'b0, {sc, " R8 done pulse"}, 32'(rsp_done), 0);
        chk(rsp_err == (err_at >= 0), {sc, " R10 err held"}, 32'(rsp_err), 32'(err_at >= 0));
        err_en = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!req_busy && !bus_cs && !bus_oe && !bus_last && !rsp_valid && !rsp_done && !rsp_err,
            "R8 reset idle", {req_busy, bus_cs, bus_oe, bus_last, rsp_valid, rsp_done, rsp_err}, 0);
    endtask

    task automatic t_burst_basic();   run("burst_basic", 1, 2'b10, 4'd3, 2'd1, 1, 1, 3'd1, 32'h100, 5'd4, -1, 0); endtask
    task automatic t_min_timing();    run("min_timing",  1, 2'b10, 4'd0, 2'd0, 0, 0, 3'd0, 32'h40, 5'd3, -1, 0); endtask
    task automatic t_wait_clamp();    run("R4 clamp",    1, 2'b10, 4'd0, 2'd2, 1, 1, 3'd2, 32'h80, 5'd2, -1, 0); endtask
    task automatic t_extra_wait();    run("R4 extra",    1, 2'b11, 4'd6, 2'd3, 0, 1, 3'd4, 32'hC0, 5'd2, -1, 0); endtask
    task automatic t_byte_width();    run("R9 byte",     1, 2'b00, 4'd1, 2'd0, 1, 0, 3'd1, 32'h201, 5'd5, -1, 0); endtask
    task automatic t_half_width();    run("R9 half",     1, 2'b01, 4'd2, 2'd1, 0, 1, 3'd2, 32'h302, 5'd3, -1, 0); endtask
    task automatic t_split();         run("R11 split",   0, 2'b10, 4'd2, 2'd3, 1, 0, 3'd2, 32'h400, 5'd3, -1, 0); endtask
    task automatic t_err_burst();     run("R10 burst",   1, 2'b10, 4'd1, 2'd1, 0, 1, 3'd3, 32'h500, 5'd4, 2, 0); endtask
    task automatic t_err_split();     run("R10 split",   0, 2'b10, 4'd1, 2'd0, 1, 1, 3'd1, 32'h600, 5'd3, 1, 0); endtask
    task automatic t_busy_poke();     run("R1 poke",     1, 2'b10, 4'd4, 2'd1, 1, 1, 3'd2, 32'h700, 5'd2, -1, 1); endtask
    task automatic t_zero_len();      run("R1 zero len", 1, 2'b10, 4'd1, 2'd1, 0, 0, 3'd1, 32'h800, 5'd0, -1, 0); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_burst_basic();
        t_min_timing();
        t_wait_clamp();
        t_extra_wait();
        t_byte_width();
        t_half_width();
        t_split();
        t_err_burst();
        t_err_split();
        t_busy_poke();
        t_zero_len();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule